// File: doc/BRIEF.md
# PWM Ramp Timebase with Selectable Count Modes

This block supplies the shared time reference for a bank of PWM duty comparators. A counter steps once per prescaled clock tick between zero and a programmable period. A two-bit mode input selects how the count moves. It can climb and wrap, giving edge-aligned PWM. It can climb once and stop, giving a single pulse. It can ramp up and back down, giving center-aligned PWM. The fourth mode ramps up and down like the third but also flags the top turnaround, so duty values can be refreshed twice per cycle.

The count, a direction flag and a one-cycle update strobe at each period boundary go to the comparators. The comparators use the strobe to latch new duty values. The block also produces two further pulses. An interrupt pulse fires on every Nth update strobe, with N selected by the postscaler. A special-event pulse fires when the rising count reaches a programmed compare value.

A new period value may be presented at any time. It is held aside and only takes effect at the next update. The run state is controlled by separate start and stop pulses, and single-shot mode clears it by itself.

Top module: `pwm_tbase`

## Requirements
- R1: While reset is asserted and after it is released, count_o is 0, and down_o, run_o, upd_o, irq_o and sev_o are all 0.
- R2: With mode_i = 2'b00 (free running), each tick advances count_o by one up to the period P and then returns it to 0. upd_o is high for exactly the cycle in which count_o shows that 0, and down_o stays 0.
- R3: With mode_i = 2'b10 (up/down), count_o climbs from 0 to P and then descends to 0, and the pattern repeats every 2P ticks. down_o is high from the step after the top until the step that leaves 0. upd_o is high only in the cycle where count_o becomes 1 after the bottom turn.
- R4: With mode_i = 2'b01 (single shot), count_o runs 0..P once. On the following tick, count_o becomes 0 and run_o falls, and upd_o is high in that same cycle. After that the count does not move.
- R5: With mode_i = 2'b11 (up/down, double update), upd_o is high at the bottom turn as in R3. It is also high in the cycle where count_o becomes P-1 after the top turn.
- R6: presc_sel_i values 0, 1, 2 and 3 give one count step per 1, 4, 16 and 64 clock cycles. The first step lands that many cycles after run_o rises.
- R7: When the block is stopped, a pulse on run_set_i clears count_o and down_o and raises run_o. A run_set_i pulse while running has no effect. A pulse on run_clr_i drops run_o and freezes count_o. When both pulses arrive together, run_clr_i wins.
- R8: The period is taken from period_i while the block is stopped and again at every update. A change to period_i between updates does not alter the current ramp.
- R9: irq_o pulses together with every (S+1)th upd_o after a start, where S = post_sel_i (0..15).
- R10: sev_o is high for the one cycle in which count_o steps to sev_cmp_i with down_o low. A match while descending does not raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_set_i | input | 1 | Start pulse; clears and starts the count when stopped |
| run_clr_i | input | 1 | Stop pulse; freezes the count |
| mode_i | input | 2 | Count mode: 00 free, 01 single shot, 10 up/down, 11 up/down double update |
| period_i | input | 16 | Period value, held aside until the next update |
| presc_sel_i | input | 2 | Input divider select: 1, 4, 16, 64 |
| post_sel_i | input | 4 | Interrupt after post_sel_i+1 updates |
| sev_cmp_i | input | 16 | Special-event compare value |
| count_o | output | 16 | Current count |
| down_o | output | 1 | High while counting down |
| run_o | output | 1 | Timebase running |
| upd_o | output | 1 | One-cycle period-boundary update strobe |
| irq_o | output | 1 | Postscaled interrupt pulse |
| sev_o | output | 1 | Special-event pulse |

## Verification
The special-event pulse and the update strobe can land in the same cycle. With a compare value of 0 in free-running mode, the wrap step produces both, and the interrupt pulse as well when the postscaler expires. The bench runs such a configuration and samples every cycle. It requires sev_o and upd_o together exactly where count_o shows 0, and nowhere else. A second coincidence is the shadow period reload happening at the same step as the wrap. The bench judges it by the length of the ramps before and after the change.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;

  typedef enum logic [1:0] {
    TB_FREE     = 2'b00,
    TB_ONESHOT  = 2'b01,
    TB_UPDN     = 2'b10,
    TB_UPDN_DBL = 2'b11
  } tb_mode_e;

  localparam int TB_MODE_W = 2;

endpackage

// File: rtl/pwm_tbase_presc.sv
module pwm_tbase_presc #(
  parameter int SEL_W    = 2,
  parameter int STEP_LOG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  localparam int CW_RAW = STEP_LOG * ((1 << SEL_W) - 1);
  localparam int CW     = (CW_RAW < 1) ? 1 : CW_RAW;

  logic [CW-1:0] pcnt_q;
  logic [CW-1:0] pcnt_d;
  logic [CW:0]   span;
  logic [CW:0]   span_m1;
  logic [CW-1:0] lim;
  logic          tick;

  always_comb begin
    span    = {{CW{1'b0}}, 1'b1} << (sel_i * STEP_LOG);
    span_m1 = span - {{CW{1'b0}}, 1'b1};
    lim     = span_m1[CW-1:0];
  end

  always_comb begin
    tick = run_i && (pcnt_q >= lim);
    if (!run_i || tick) begin
      pcnt_d = '0;
    end else begin
      pcnt_d = pcnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
    end
  end

  assign tick_o = tick;

endmodule

// File: rtl/pwm_tbase_ramp.sv
module pwm_tbase_ramp
  import pwm_tbase_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          tick_i,
  input  tb_mode_e      mode_i,
  input  logic [CW-1:0] per_i,
  output logic [CW-1:0] cnt_o,
  output logic          dn_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          dn_nxt_o,
  output logic          top_o,
  output logic          bot_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          dn_q;
  logic          dn_d;
  logic          at_top;
  logic          at_bot;
  logic          bidir;
  logic          cnt_en;

  assign bidir  = (mode_i == TB_UPDN) || (mode_i == TB_UPDN_DBL);
  assign cnt_en = start_i || tick_i;

  always_comb begin
    cnt_d  = cnt_q;
    dn_d   = dn_q;
    at_top = 1'b0;
    at_bot = 1'b0;
    if (start_i) begin
      cnt_d = '0;
      dn_d  = 1'b0;
    end else if (tick_i) begin
      if (!bidir) begin
        dn_d = 1'b0;
        if (cnt_q >= per_i) begin
          cnt_d  = '0;
          at_top = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end else if (!dn_q) begin
        if (cnt_q >= per_i) begin
          at_top = 1'b1;
          dn_d   = 1'b1;
          cnt_d  = (cnt_q == '0) ? '0 : cnt_q - CW'(1);
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end else begin
        if (cnt_q == '0) begin
          at_bot = 1'b1;
          dn_d   = 1'b0;
          cnt_d  = (per_i == '0) ? '0 : CW'(1);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign dn_o      = dn_q;
  assign cnt_nxt_o = cnt_d;
  assign dn_nxt_o  = dn_d;
  assign top_o     = at_top;
  assign bot_o     = at_bot;

endmodule

// File: rtl/pwm_tbase_post.sv
module pwm_tbase_post #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ev_i,
  input  logic [PW-1:0] sel_i,
  output logic          irq_o
);

  logic [PW-1:0] ecnt_q;
  logic [PW-1:0] ecnt_d;
  logic          irq_q;
  logic          irq_d;

  always_comb begin
    ecnt_d = ecnt_q;
    irq_d  = 1'b0;
    if (start_i) begin
      ecnt_d = '0;
    end else if (ev_i) begin
      if (ecnt_q >= sel_i) begin
        ecnt_d = '0;
        irq_d  = 1'b1;
      end else begin
        ecnt_d = ecnt_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ecnt_q <= ecnt_d;
      irq_q  <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/pwm_tbase.sv
module pwm_tbase
  import pwm_tbase_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRE_SEL_W = 2,
  parameter int PRE_STEP = 2,
  parameter int POST_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_set_i,
  input  logic                 run_clr_i,
  input  logic [TB_MODE_W-1:0] mode_i,
  input  logic [CNT_W-1:0]     period_i,
  input  logic [PRE_SEL_W-1:0] presc_sel_i,
  input  logic [POST_W-1:0]    post_sel_i,
  input  logic [CNT_W-1:0]     sev_cmp_i,
  output logic [CNT_W-1:0]     count_o,
  output logic                 down_o,
  output logic                 run_o,
  output logic                 upd_o,
  output logic                 irq_o,
  output logic                 sev_o
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rsync_q[SYNC_STAGES-1];

  tb_mode_e       mode;
  logic           run_q;
  logic           run_d;
  logic           start;
  logic           tick;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] per_d;
  logic [CNT_W-1:0] cnt_nxt;
  logic           dn_nxt;
  logic           at_top;
  logic           at_bot;
  logic           bound;
  logic           upd_q;
  logic           sev_q;
  logic           sev_d;

  assign mode  = tb_mode_e'(mode_i);
  assign start = run_set_i && !run_q && !run_clr_i;

  always_comb begin
    unique case (mode)
      TB_FREE, TB_ONESHOT: bound = at_top;
      TB_UPDN:             bound = at_bot;
      default:             bound = at_top || at_bot;
    endcase
  end

  always_comb begin
    run_d = run_q;
    if (run_clr_i) begin
      run_d = 1'b0;
    end else if (start) begin
      run_d = 1'b1;
    end else if (at_top && (mode == TB_ONESHOT)) begin
      run_d = 1'b0;
    end
  end

  always_comb begin
    per_d = per_q;
    if (!run_q || bound) begin
      per_d = period_i;
    end
  end

  assign sev_d = tick && !dn_nxt && (cnt_nxt == sev_cmp_i);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      run_q <= 1'b0;
      per_q <= '0;
      upd_q <= 1'b0;
      sev_q <= 1'b0;
    end else begin
      run_q <= run_d;
      per_q <= per_d;
      upd_q <= bound;
      sev_q <= sev_d;
    end
  end

  pwm_tbase_presc #(
    .SEL_W    (PRE_SEL_W),
    .STEP_LOG (PRE_STEP)
  ) presc_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (run_q),
    .sel_i  (presc_sel_i),
    .tick_o (tick)
  );

  pwm_tbase_ramp #(
    .CW (CNT_W)
  ) ramp_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start),
    .tick_i    (tick),
    .mode_i    (mode),
    .per_i     (per_q),
    .cnt_o     (count_o),
    .dn_o      (down_o),
    .cnt_nxt_o (cnt_nxt),
    .dn_nxt_o  (dn_nxt),
    .top_o     (at_top),
    .bot_o     (at_bot)
  );

  pwm_tbase_post #(
    .PW (POST_W)
  ) post_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start),
    .ev_i    (bound),
    .sel_i   (post_sel_i),
    .irq_o   (irq_o)
  );

  assign run_o = run_q;
  assign upd_o = upd_q;
  assign sev_o = sev_q;

endmodule

// File: rtl/pwm_tbase_chk.sv
module pwm_tbase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_set_i,
  input logic             run_clr_i,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] count_o,
  input logic             down_o,
  input logic             run_o,
  input logic             upd_o,
  input logic             irq_o,
  input logic             sev_o
);

  // R2 / R3: the count moves by one step, or restarts at zero
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + CNT_W'(1)) ||
             (count_o == $past(count_o) - CNT_W'(1)) || (count_o == '0));

  // R7: a stopped timebase that is not started keeps its count
  a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !run_set_i) |=> $stable(count_o));

  // R4: a self-stop coincides with the update strobe and a zero count
  a_r4_oneshot_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run_o) && !$past(run_clr_i)) |-> (upd_o && (count_o == '0)));

  // R9: the interrupt only accompanies an update strobe
  a_r9_irq_with_upd: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> upd_o);

  // R3: counting down only begins in a bidirectional mode
  a_r3_dir_bidir: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(down_o) |-> $past(mode_i[1]));

  // R10: the special event is only flagged on the rising ramp
  a_r10_sev_rising: assert property (@(posedge clk) disable iff (!rst_n)
    sev_o |-> !down_o);

endmodule

bind pwm_tbase pwm_tbase_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_set_i (run_set_i),
  .run_clr_i (run_clr_i),
  .mode_i    (mode_i),
  .count_o   (count_o),
  .down_o    (down_o),
  .run_o     (run_o),
  .upd_o     (upd_o),
  .irq_o     (irq_o),
  .sev_o     (sev_o)
);

// File: tb/pwm_tbase_tb_top.sv
module pwm_tbase_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  logic        clk;
  logic        rst_n;
  logic        run_set_i;
  logic        run_clr_i;
  logic [1:0]  mode_i;
  logic [15:0] period_i;
  logic [1:0]  presc_sel_i;
  logic [3:0]  post_sel_i;
  logic [15:0] sev_cmp_i;
  logic [15:0] count_o;
  logic        down_o;
  logic        run_o;
  logic        upd_o;
  logic        irq_o;
  logic        sev_o;

  int n_chk;
  int n_bad;
  int cyc;

  pwm_tbase dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_set_i   (run_set_i),
    .run_clr_i   (run_clr_i),
    .mode_i      (mode_i),
    .period_i    (period_i),
    .presc_sel_i (presc_sel_i),
    .post_sel_i  (post_sel_i),
    .sev_cmp_i   (sev_cmp_i),
    .count_o     (count_o),
    .down_o      (down_o),
    .run_o       (run_o),
    .upd_o       (upd_o),
    .irq_o       (irq_o),
    .sev_o       (sev_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG_CYC) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // restart sequence; after return, one edge has passed since the start pulse
  task automatic launch(input logic [1:0] m, input int per, input int psel,
                        input int post, input int cmp);
    @(negedge clk);
    run_clr_i = 1'b1;
    @(negedge clk);
    run_clr_i   = 1'b0;
    mode_i      = m;
    period_i    = 16'(per);
    presc_sel_i = 2'(psel);
    post_sel_i  = 4'(post);
    sev_cmp_i   = 16'(cmp);
    run_set_i   = 1'b1;
    @(negedge clk);
    run_set_i = 1'b0;
    chk("R7", "start count", int'(count_o), 0);
    chk("R7", "start run", int'(run_o), 1);
  endtask

  function automatic int tri_cnt(input int t, input int p);
    int r;
    r = t % (2 * p);
    return (r <= p) ? r : (2 * p - r);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    run_set_i = 1'b0; run_clr_i = 1'b0; mode_i = 2'b00; period_i = 16'd0;
    presc_sel_i = 2'd0; post_sel_i = 4'd0; sev_cmp_i = 16'd0;
    repeat (3) @(negedge clk);
    chk("R1", "count in reset", int'(count_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "count", int'(count_o), 0);
    chk("R1", "down", int'(down_o), 0);
    chk("R1", "run", int'(run_o), 0);
    chk("R1", "strobes", int'({upd_o, irq_o, sev_o}), 0);
  endtask

  // free running with compare 0: event and update coincide at wrap
  task automatic t_free();
    launch(2'b00, 5, 0, 0, 0);
    for (int j = 1; j <= 14; j++) begin
      @(negedge clk);
      chk("R2", "free count", int'(count_o), j % 6);
      chk("R2", "free upd", int'(upd_o), int'(j % 6 == 0));
      chk("R2", "free down", int'(down_o), 0);
      chk("R10", "sev at wrap", int'(sev_o), int'(j % 6 == 0));
    end
  endtask

  task automatic t_presc();
    launch(2'b00, 3, 1, 0, 999);
    for (int j = 1; j <= 20; j++) begin
      @(negedge clk);
      chk("R6", "div4 count", int'(count_o), (j / 4) % 4);
    end
    launch(2'b00, 100, 2, 0, 999);
    for (int j = 1; j <= 16; j++) begin
      @(negedge clk);
      if (j == 15) chk("R6", "div16 before", int'(count_o), 0);
      if (j == 16) chk("R6", "div16 step", int'(count_o), 1);
    end
    launch(2'b00, 100, 3, 0, 999);
    for (int j = 1; j <= 64; j++) begin
      @(negedge clk);
      if (j == 63) chk("R6", "div64 before", int'(count_o), 0);
      if (j == 64) chk("R6", "div64 step", int'(count_o), 1);
    end
  endtask

  task automatic t_oneshot();
    launch(2'b01, 3, 0, 0, 999);
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      chk("R4", "shot count", int'(count_o), (j <= 3) ? j : 0);
      chk("R4", "shot run", int'(run_o), int'(j <= 3));
      chk("R4", "shot upd", int'(upd_o), int'(j == 4));
    end
  endtask

  task automatic t_updn(input logic dbl);
    int r;
    launch(dbl ? 2'b11 : 2'b10, 4, 0, 0, 2);
    for (int j = 1; j <= 20; j++) begin
      @(negedge clk);
      r = j % 8;
      chk("R3", "ramp count", int'(count_o), tri_cnt(j, 4));
      chk("R3", "ramp down", int'(down_o), int'(r >= 5 || r == 0));
      if (dbl)
        chk("R5", "dbl upd", int'(upd_o), int'((r == 1 && j > 1) || r == 5));
      else
        chk("R3", "bottom upd", int'(upd_o), int'(r == 1 && j > 1));
      chk("R10", "sev rising only", int'(sev_o), int'(r == 2));
    end
  endtask

  task automatic t_shadow();
    launch(2'b00, 5, 0, 0, 999);
    for (int j = 1; j <= 9; j++) begin
      @(negedge clk);
      if (j >= 3 && j <= 5) chk("R8", "old period kept", int'(count_o), j);
      if (j == 6) chk("R8", "wrap old period", int'(count_o), 0);
      if (j == 8) chk("R8", "new top", int'(count_o), 2);
      if (j == 9) begin
        chk("R8", "new wrap", int'(count_o), 0);
        chk("R8", "new wrap upd", int'(upd_o), 1);
      end
      if (j == 2) period_i = 16'd2;
    end
  endtask

  task automatic t_post();
    launch(2'b00, 1, 0, 2, 999);
    for (int j = 1; j <= 14; j++) begin
      @(negedge clk);
      chk("R9", "irq every 3rd", int'(irq_o), int'(j % 6 == 0));
    end
    launch(2'b00, 1, 0, 0, 999);
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      chk("R9", "irq every upd", int'(irq_o), int'(j % 2 == 0));
    end
  endtask

  task automatic t_run();
    int held;
    launch(2'b00, 10, 0, 0, 999);
    repeat (4) @(negedge clk);
    chk("R7", "running count", int'(count_o), 4);
    run_set_i = 1'b1;
    @(negedge clk);
    run_set_i = 1'b0;
    chk("R7", "set while running ignored", int'(count_o), 5);
    run_clr_i = 1'b1;
    @(negedge clk);
    run_clr_i = 1'b0;
    chk("R7", "stopped", int'(run_o), 0);
    held = int'(count_o);
    repeat (3) @(negedge clk);
    chk("R7", "frozen count", int'(count_o), held);
    run_set_i = 1'b1;
    run_clr_i = 1'b1;
    @(negedge clk);
    run_set_i = 1'b0;
    run_clr_i = 1'b0;
    chk("R7", "clr wins run", int'(run_o), 0);
    chk("R7", "clr wins count", int'(count_o), held);
    run_set_i = 1'b1;
    @(negedge clk);
    run_set_i = 1'b0;
    chk("R7", "restart clears", int'(count_o), 0);
    chk("R7", "restart runs", int'(run_o), 1);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    cyc   = 0;
    t_reset();
    t_free();
    t_presc();
    t_oneshot();
    t_updn(1'b0);
    t_updn(1'b1);
    t_shadow();
    t_post();
    t_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule